// File: doc/BRIEF.md
# Vertical Timing Pulse Generator

This block sits behind a synchronized vertical divider. It turns the divider's half-line count, its lock mode and its reset strobe into the timing pulses that the vertical section needs. These are the sawtooth charge enable, the vertical blanking pulse, the anti-top-flutter inhibit for the horizontal phase detector and the inhibit for the sync slicing-level detector. It also produces a 2-bit code that selects one of the three sandcastle output levels, or none. The code combines the vertical pulses with the horizontal flyback and burst-key pulses.

When the divider is locked in the narrow-window or standard mode, vertical blanking is extended backwards to the first equalizing pulse. It then lasts 42 half-lines in place of 34. A guard flag that reports an out-of-range vertical feedback level holds the vertical blanking level on the sandcastle code continuously, so the picture is blanked.

The count advances in half-lines and reads 0 in the cycle in which the reset strobe is high. Each output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `vtiming_top`

## Requirements
- R1: After the first divider reset, `sawCharge` is high exactly while `count` < 26.
- R2: After the first divider reset, `vBlank` is high exactly while `count` < 34.
- R3: In search mode (`mode` = 00, and also the unused code 11), `atfPulse` is high exactly while `count` < 12.
- R4: In narrow mode (`mode` = 01) or standard mode (`mode` = 10), `atfPulse` is high while `count` < 12 or `count` >= 517, which is 8 half-lines before the nominal 525 reset. The composite vertical blanking therefore spans 42 half-lines in these modes and 34 in search mode.
- R5: `sliceInhibit` is high while `count` >= 517 in narrow or standard mode, and is never high in search mode.
- R6: `scCode` uses a fixed priority. It is 11 when the burst key is high, otherwise 10 when the flyback is high, otherwise 01 when the composite vertical blanking (`vBlank` OR `atfPulse`) is high, and otherwise 00.
- R7: While `guardFlag` is high, `scCode` is at least 01 regardless of the count. Burst key and flyback still take precedence over it.
- R8: Before the first `divReset` after reset, the vertical pulse outputs (`sawCharge`, `vBlank`, `atfPulse`, `sliceInhibit`) stay low for any count.
- R9: During `rstN` low all outputs are 0. Every output follows its inputs with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | 10 | Divider half-line count, 0 at the reset strobe |
| mode | input | 2 | Divider mode: 00 search, 01 narrow, 10 standard |
| divReset | input | 1 | Divider reset strobe, one cycle wide |
| guardFlag | input | 1 | Vertical feedback out of range |
| hFlyback | input | 1 | Horizontal flyback pulse |
| burstKey | input | 1 | Burst key pulse |
| sawCharge | output | 1 | Sawtooth charge enable |
| vBlank | output | 1 | Vertical blanking pulse |
| atfPulse | output | 1 | Anti-top-flutter inhibit |
| sliceInhibit | output | 1 | Slicing-level detector inhibit |
| scCode | output | 2 | Sandcastle level code |

## Verification
The count is swept from 0 up past the 576 search limit once for each of the four mode codes. Each sweep starts with a divider reset, so the search pattern and the locked pattern are told apart by where the anti-top-flutter pulse and the slicer inhibit begin. The guard, flyback and burst inputs toggle on co-prime periods across the sweep, which exercises every priority overlap of the sandcastle code at both blanking and non-blanking counts. A run of counts driven before any divider reset separates the armed decode from the unarmed one.

// File: rtl/vtiming_pkg.sv
package vtiming_pkg;

  typedef enum logic [1:0] {
    MODE_SEARCH = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_STD    = 2'b10,
    MODE_RSVD   = 2'b11
  } divMode_t;

  typedef struct packed {
    logic armed;
    logic locked;
  } ctrlStrobe_t;

  localparam logic [1:0] SC_NONE  = 2'b00;
  localparam logic [1:0] SC_VERT  = 2'b01;
  localparam logic [1:0] SC_HORIZ = 2'b10;
  localparam logic [1:0] SC_BURST = 2'b11;

endpackage

// File: rtl/vtiming_ctrl.sv
module vtiming_ctrl
  import vtiming_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        divReset,
  input  divMode_t    mode,
  output ctrlStrobe_t strb
);

  logic armedQ;

  always_ff @(posedge clk) begin
    if (!rstN)         armedQ <= 1'b0;
    else if (divReset) armedQ <= 1'b1;
  end

  always_comb begin
    strb.armed  = armedQ | divReset;
    strb.locked = (mode == MODE_NARROW) || (mode == MODE_STD);
  end

  // R8: the armed state is only ever entered through a divider reset
  assert_arm_needs_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(divReset));

endmodule

// File: rtl/vtiming_dp.sv
module vtiming_dp
  import vtiming_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int NOMINAL   = 525,
  parameter int SAW_LEN   = 26,
  parameter int BLANK_END = 34,
  parameter int EQ_PRE    = 8,
  parameter int EQ_POST   = 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [CNT_W-1:0] count,
  input  logic             guardFlag,
  input  logic             hFlyback,
  input  logic             burstKey,
  output logic             sawCharge,
  output logic             vBlank,
  output logic             atfPulse,
  output logic             sliceInhibit,
  output logic [1:0]       scCode
);

  localparam logic [CNT_W-1:0] SawEnd   = CNT_W'(SAW_LEN);
  localparam logic [CNT_W-1:0] BlankEnd = CNT_W'(BLANK_END);
  localparam logic [CNT_W-1:0] AtfEnd   = CNT_W'(EQ_POST);
  localparam logic [CNT_W-1:0] EqStart  = CNT_W'(NOMINAL - EQ_PRE);

  logic chargeD, blankD, atfD, preEqD, sliceD, vertD;
  logic [1:0] codeD;
  logic pastValid;

  always_comb begin
    preEqD  = strb.locked && (count >= EqStart);
    chargeD = strb.armed && (count < SawEnd);
    blankD  = strb.armed && (count < BlankEnd);
    atfD    = strb.armed && ((count < AtfEnd) || preEqD);
    sliceD  = strb.armed && preEqD;
    vertD   = blankD || atfD || guardFlag;
    if (burstKey)      codeD = SC_BURST;
    else if (hFlyback) codeD = SC_HORIZ;
    else if (vertD)    codeD = SC_VERT;
    else               codeD = SC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sawCharge    <= 1'b0;
      vBlank       <= 1'b0;
      atfPulse     <= 1'b0;
      sliceInhibit <= 1'b0;
      scCode       <= SC_NONE;
      pastValid    <= 1'b0;
    end else begin
      sawCharge    <= chargeD;
      vBlank       <= blankD;
      atfPulse     <= atfD;
      sliceInhibit <= sliceD;
      scCode       <= codeD;
      pastValid    <= 1'b1;
    end
  end

  assert_charge_in_blank_R1: assert property (@(posedge clk) disable iff (!rstN)
    sawCharge |-> vBlank);

  assert_slice_in_atf_R5: assert property (@(posedge clk) disable iff (!rstN)
    sliceInhibit |-> atfPulse);

  assert_burst_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(burstKey)) |-> (scCode == SC_BURST));

  assert_guard_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(guardFlag)) |-> (scCode != SC_NONE));

endmodule

// File: rtl/vtiming_top.sv
module vtiming_top
  import vtiming_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int NOMINAL   = 525,
  parameter int SAW_LEN   = 26,
  parameter int BLANK_END = 34,
  parameter int EQ_PRE    = 8,
  parameter int EQ_POST   = 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       mode,
  input  logic             divReset,
  input  logic             guardFlag,
  input  logic             hFlyback,
  input  logic             burstKey,
  output logic             sawCharge,
  output logic             vBlank,
  output logic             atfPulse,
  output logic             sliceInhibit,
  output logic [1:0]       scCode
);

  ctrlStrobe_t strb;

  vtiming_ctrl ctrl (
    .clk(clk), .rstN(rstN), .divReset(divReset),
    .mode(divMode_t'(mode)), .strb(strb)
  );

  vtiming_dp #(
    .CNT_W(CNT_W), .NOMINAL(NOMINAL), .SAW_LEN(SAW_LEN),
    .BLANK_END(BLANK_END), .EQ_PRE(EQ_PRE), .EQ_POST(EQ_POST)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count),
    .guardFlag(guardFlag), .hFlyback(hFlyback), .burstKey(burstKey),
    .sawCharge(sawCharge), .vBlank(vBlank), .atfPulse(atfPulse),
    .sliceInhibit(sliceInhibit), .scCode(scCode)
  );

endmodule

// File: tb/vtiming_top_test.sv
`timescale 1ns/1ps
module vtiming_top_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] count = '0;
  logic [1:0] mode = '0;
  logic divReset = 1'b0, guardFlag = 1'b0, hFlyback = 1'b0, burstKey = 1'b0;
  logic sawCharge, vBlank, atfPulse, sliceInhibit;
  logic [1:0] scCode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit armedM = 0;

  always #2.5 clk = ~clk;

  vtiming_top uut (
    .clk(clk), .rstN(rstN), .count(count), .mode(mode), .divReset(divReset),
    .guardFlag(guardFlag), .hFlyback(hFlyback), .burstKey(burstKey),
    .sawCharge(sawCharge), .vBlank(vBlank), .atfPulse(atfPulse),
    .sliceInhibit(sliceInhibit), .scCode(scCode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (count=%0d mode=%0d)",
               req, what, act, exp, count, mode);
    end
  endtask

  // called at a negedge: drive, wait one full cycle, compare
  task automatic step(input int c, input int m, input bit rs, input bit g,
                      input bit f, input bit b);
    bit arm, locked, eChg, eBlk, eAtf, eSl;
    int eCode;
    count = 10'(c); mode = 2'(m); divReset = rs;
    guardFlag = g; hFlyback = f; burstKey = b;
    arm    = armedM | rs;
    locked = (m == 1) || (m == 2);
    eChg = arm && (c < 26);
    eBlk = arm && (c < 34);
    eAtf = arm && ((c < 12) || (locked && c >= 517));
    eSl  = arm && locked && (c >= 517);
    if (b) eCode = 3;
    else if (f) eCode = 2;
    else if (eBlk || eAtf || g) eCode = 1;
    else eCode = 0;
    if (rs) armedM = 1;
    @(negedge clk);
    chk("R1", "sawCharge", sawCharge, eChg);
    chk("R2", "vBlank", vBlank, eBlk);
    chk(locked ? "R4" : "R3", "atfPulse", atfPulse, eAtf);
    chk("R5", "sliceInhibit", sliceInhibit, eSl);
    chk((g && !b && !f) ? "R7" : "R6", "scCode", scCode, eCode);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state with active inputs
    burstKey = 1'b1; guardFlag = 1'b1; divReset = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "reset scCode", scCode, 0);
    chk("R9", "reset vBlank", vBlank, 0);
    chk("R9", "reset sawCharge", sawCharge, 0);
    burstKey = 1'b0; guardFlag = 1'b0; divReset = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // R8: unarmed decode at counts that would otherwise pulse
    for (int c = 0; c < 40; c++) step(c, 1, 0, 0, 0, 0);
    for (int c = 515; c < 530; c++) step(c, 2, 0, 0, 0, 0);
    step(3, 0, 0, 1, 0, 0);   // R7 guard while unarmed
    // full sweeps, one per mode code, each begun by a divider reset
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c <= 580; c++) begin
        step(c, m, c == 0, (c % 7) == 3, (c % 5) == 1, (c % 11) == 2);
      end
    end
    // R9: latency, one cycle exactly; a pulse held one cycle shows up once
    step(100, 0, 0, 0, 0, 1);
    step(100, 0, 0, 0, 0, 0);
    chk("R9", "burst gone after one cycle", scCode, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule